// File: doc/BRIEF.md
# Raster Scanout Engine with Pixel Unpacking

This block drives a display in the manner of a CRT controller. Two free-running counters walk every position of a frame, including the blanking intervals. From the counter values the block derives horizontal sync, vertical sync, a data-enable flag and an end-of-frame pulse. The active, front-porch, sync and back-porch lengths of each axis are all parameters.

While the counters are inside the active area, the block turns the current position into a byte address in an external framebuffer RAM. It does this from a packed 64-bit buffer-configuration word, which carries a base pointer, a row width and a pixel storage format. One cycle later the RAM returns a 32-bit word. The block unpacks that word according to the format and drives 8-bit red, green and blue outputs.

A second 64-bit word limits the visible window. Bit 0 of a 64-bit mode word is the master enable. All three words may change at any time, including while scanout is disabled.

Top module: `fb_scanout`

## Requirements
- R1: Horizontal sync is active for H_SYNC cycles, starting H_ACTIVE+H_FRONT cycles into each line of H_ACTIVE+H_FRONT+H_SYNC+H_BACK cycles. Vertical sync is active for V_SYNC whole lines, starting at line V_ACTIVE+V_FRONT. Sync is active-high unless SYNC_LOW is set.
- R2: Data-enable is high exactly for the first H_ACTIVE positions of each of the first V_ACTIVE lines.
- R3: The end-of-frame output is a single-cycle pulse, once per frame. It appears with the final blanking position of the frame (last column of the last line), so data-enable is low whenever it is high.
- R4: During the active area the RAM byte address is fbp·8192 + y·fbw·64·bpp + x·bpp. Here fbp is buffer-config bits [8:0], fbw is bits [14:9], bpp is 4 or 2, and x, y count from 0 at the first active pixel. The address is presented one cycle before that pixel appears on the outputs.
- R5: Format code 0 in buffer-config bits [19:15] selects 32-bit pixels. In this format red is RAM data [7:0], green is [15:8] and blue is [23:16]; bits [31:24] are unused.
- R6: Format code 2 selects 16-bit pixels. Red is bits [4:0], green is bits [9:5] and blue is bits [14:10] of the 16-bit pixel. The pixel is taken from the upper half of the RAM word when address bit 1 is set, and from the lower half otherwise. Each 5-bit channel c widens to {c, c[4:2]}, so 0x10→0x84, 0x18→0xC6 and 0x08→0x42.
- R7: The colour outputs are zero when any of the following holds: data-enable is low, mode-word bit 0 was clear when the pixel was fetched, x exceeds area-config bits [43:32], or y exceeds area-config bits [54:44].
- R8: Any format code other than 0 or 2 yields zero colour.
- R9: During reset all outputs are zero and the counters sit at the first active position. All-zero configuration words are accepted without fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_cfg | input | 64 | Mode word; bit 0 enables scanout |
| fb_cfg | input | 64 | Buffer configuration: pointer, width, format |
| area_cfg | input | 64 | Visible window: width-1 at [43:32], height-1 at [54:44] |
| ram_addr | output | ADDR_W | Byte address to the framebuffer RAM |
| ram_rdata | input | 32 | RAM read data, one cycle after the address |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data-enable, high in the active area |
| frame_end | output | 1 | One-cycle pulse at the last position of a frame |
| red | output | 8 | Red channel |
| green | output | 8 | Green channel |
| blue | output | 8 | Blue channel |

## Verification
The RAM address is combinational from the counters and the configuration words, so it is checked in the same cycle as the position it belongs to. Sync, data-enable, end-of-frame and colour all trail that position by exactly one register stage. The bench model therefore freezes its prediction for a position at the clock edge that leaves that position, and compares it with the outputs at the following falling edge. The bench RAM answers with one cycle of latency, and configuration words change just after a rising edge. Each mid-frame change of format, pointer, window or enable is therefore picked up by the model at the same edge as by the design.

// File: rtl/scan_pkg.sv
package scan_pkg;
   // Internal format classification after decoding the 5-bit storage field
   localparam logic [1:0] FMT_NONE = 2'd0;
   localparam logic [1:0] FMT_W32  = 2'd1;
   localparam logic [1:0] FMT_W16  = 2'd2;

   // Bit positions inside the packed configuration words
   localparam int PTR_LO = 0;
   localparam int WID_LO = 9;
   localparam int FMT_LO = 15;
   localparam int DWX_LO = 32;
   localparam int DHY_LO = 44;

   // Everything carried from the address cycle to the pixel cycle
   typedef struct packed {
      logic       act;
      logic       win;
      logic       hs;
      logic       vs;
      logic       eof;
      logic       half;
      logic [1:0] fmt;
      logic       en;
   } stage_t;

   function automatic logic [7:0] widen5(input logic [4:0] c);
      return {c, c[4:2]};
   endfunction
endpackage

// File: rtl/scan_timing.sv
module scan_timing #(
   parameter int H_ACTIVE = 16,
   parameter int H_FRONT  = 2,
   parameter int H_SYNC   = 2,
   parameter int H_BACK   = 2,
   parameter int V_ACTIVE = 8,
   parameter int V_FRONT  = 1,
   parameter int V_SYNC   = 1,
   parameter int V_BACK   = 1,
   parameter int HW       = 5,
   parameter int VW       = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [HW-1:0] hpos,
   output logic [VW-1:0] vpos,
   output logic          act,
   output logic          hs,
   output logic          vs,
   output logic          eof
);
   localparam int HTOT   = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
   localparam int VTOT   = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
   localparam int HS_BEG = H_ACTIVE + H_FRONT;
   localparam int HS_END = HS_BEG + H_SYNC;
   localparam int VS_BEG = V_ACTIVE + V_FRONT;
   localparam int VS_END = VS_BEG + V_SYNC;
   localparam logic [HW-1:0] H_LAST = HW'(HTOT - 1);
   localparam logic [VW-1:0] V_LAST = VW'(VTOT - 1);

   logic [HW-1:0] hcnt;
   logic [VW-1:0] vcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt <= '0;
         vcnt <= '0;
      end else if (hcnt == H_LAST) begin
         hcnt <= '0;
         vcnt <= (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
      end else begin
         hcnt <= hcnt + 1'b1;
      end
   end

   always_comb begin
      hpos = hcnt;
      vpos = vcnt;
      act  = (int'(hcnt) < H_ACTIVE) && (int'(vcnt) < V_ACTIVE);
      hs   = (int'(hcnt) >= HS_BEG) && (int'(hcnt) < HS_END);
      vs   = (int'(vcnt) >= VS_BEG) && (int'(vcnt) < VS_END);
      eof  = (hcnt == H_LAST) && (vcnt == V_LAST);
   end
endmodule

// File: rtl/scan_addr.sv
module scan_addr
   import scan_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int HW     = 5,
   parameter int VW     = 4
) (
   input  logic [HW-1:0]     hpos,
   input  logic [VW-1:0]     vpos,
   input  logic [63:0]       fb_cfg,
   input  logic [63:0]       area_cfg,
   output logic [ADDR_W-1:0] addr,
   output logic              win,
   output logic [1:0]        fmt
);
   logic [8:0]        ptr;
   logic [5:0]        wid;
   logic [4:0]        code;
   logic [ADDR_W-1:0] base, stride, xoff;

   always_comb begin
      ptr  = fb_cfg[PTR_LO +: 9];
      wid  = fb_cfg[WID_LO +: 6];
      code = fb_cfg[FMT_LO +: 5];
      unique case (code)
         5'd0:    fmt = FMT_W32;
         5'd2:    fmt = FMT_W16;
         default: fmt = FMT_NONE;
      endcase
      base = ADDR_W'(ptr) << 13;
      if (fmt == FMT_W16) begin
         stride = ADDR_W'(wid) << 7;
         xoff   = ADDR_W'(hpos) << 1;
      end else begin
         stride = ADDR_W'(wid) << 8;
         xoff   = ADDR_W'(hpos) << 2;
      end
      addr = base + ADDR_W'(vpos) * stride + xoff;
      win  = (32'(hpos) <= 32'(area_cfg[DWX_LO +: 12]))
          && (32'(vpos) <= 32'(area_cfg[DHY_LO +: 11]));
   end
endmodule

// File: rtl/scan_decode.sv
module scan_decode
   import scan_pkg::*;
(
   input  logic [31:0] word,
   input  logic        half,
   input  logic [1:0]  fmt,
   input  logic        show,
   output logic [7:0]  r,
   output logic [7:0]  g,
   output logic [7:0]  b
);
   logic [15:0] px;

   always_comb begin
      px = half ? word[31:16] : word[15:0];
      r  = '0;
      g  = '0;
      b  = '0;
      if (show) begin
         unique case (fmt)
            FMT_W32: begin
               r = word[7:0];
               g = word[15:8];
               b = word[23:16];
            end
            FMT_W16: begin
               r = widen5(px[4:0]);
               g = widen5(px[9:5]);
               b = widen5(px[14:10]);
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/fb_scanout.sv
module fb_scanout
   import scan_pkg::*;
#(
   parameter int H_ACTIVE = 16,
   parameter int H_FRONT  = 2,
   parameter int H_SYNC   = 2,
   parameter int H_BACK   = 2,
   parameter int V_ACTIVE = 8,
   parameter int V_FRONT  = 1,
   parameter int V_SYNC   = 1,
   parameter int V_BACK   = 1,
   parameter int ADDR_W   = 32,
   parameter bit SYNC_LOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [63:0]       mode_cfg,
   input  logic [63:0]       fb_cfg,
   input  logic [63:0]       area_cfg,
   output logic [ADDR_W-1:0] ram_addr,
   input  logic [31:0]       ram_rdata,
   output logic              hsync,
   output logic              vsync,
   output logic              de,
   output logic              frame_end,
   output logic [7:0]        red,
   output logic [7:0]        green,
   output logic [7:0]        blue
);
   localparam int HTOT = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
   localparam int VTOT = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
   localparam int HW   = (HTOT > 1) ? $clog2(HTOT) : 1;
   localparam int VW   = (VTOT > 1) ? $clog2(VTOT) : 1;

   if (H_ACTIVE < 1 || H_FRONT < 1 || H_SYNC < 1 || H_BACK < 1) begin : g_bad_h
      $fatal(1, "horizontal timing lengths must all be at least 1");
   end
   if (V_ACTIVE < 1 || V_FRONT < 1 || V_SYNC < 1 || V_BACK < 1) begin : g_bad_v
      $fatal(1, "vertical timing lengths must all be at least 1");
   end
   if (ADDR_W < 23) begin : g_bad_a
      $fatal(1, "ADDR_W too narrow for the base pointer range");
   end

   logic [HW-1:0]     hpos;
   logic [VW-1:0]     vpos;
   logic              act, hs, vs, eof, win;
   logic [1:0]        fmt;
   stage_t            st_d, st_q;

   scan_timing #(
      .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
      .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK),
      .HW(HW), .VW(VW)
   ) u_timing (
      .clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos),
      .act(act), .hs(hs), .vs(vs), .eof(eof)
   );

   scan_addr #(.ADDR_W(ADDR_W), .HW(HW), .VW(VW)) u_addr (
      .hpos(hpos), .vpos(vpos), .fb_cfg(fb_cfg), .area_cfg(area_cfg),
      .addr(ram_addr), .win(win), .fmt(fmt)
   );

   always_comb begin
      st_d.act  = act;
      st_d.win  = win;
      st_d.hs   = hs;
      st_d.vs   = vs;
      st_d.eof  = eof;
      st_d.half = ram_addr[1];
      st_d.fmt  = fmt;
      st_d.en   = mode_cfg[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_d;
   end

   scan_decode u_decode (
      .word(ram_rdata), .half(st_q.half), .fmt(st_q.fmt),
      .show(st_q.act & st_q.win & st_q.en),
      .r(red), .g(green), .b(blue)
   );

   if (SYNC_LOW) begin : g_sync_low
      assign hsync = ~st_q.hs;
      assign vsync = ~st_q.vs;
   end else begin : g_sync_high
      assign hsync = st_q.hs;
      assign vsync = st_q.vs;
   end

   assign de        = st_q.act;
   assign frame_end = st_q.eof;
endmodule

// File: rtl/scan_checker.sv
module scan_checker #(
   parameter bit SYNC_LOW = 1'b0
) (
   input logic        clk,
   input logic        rst_n,
   input logic [63:0] mode_cfg,
   input logic        hsync,
   input logic        vsync,
   input logic        de,
   input logic        frame_end,
   input logic [7:0]  red,
   input logic [7:0]  green,
   input logic [7:0]  blue
);
   AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
      !de |-> ({red, green, blue} == 24'd0)); // R7
   AST_OFF_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(mode_cfg[0]) |-> ({red, green, blue} == 24'd0)); // R7
   AST_EOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> !frame_end); // R3
   AST_EOF_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |-> !de); // R3
   AST_ACTIVE_NO_HSYNC: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> (hsync == SYNC_LOW)); // R1
   AST_ACTIVE_NO_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> (vsync == SYNC_LOW)); // R1
endmodule

bind fb_scanout scan_checker #(.SYNC_LOW(SYNC_LOW)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .hsync(hsync),
   .vsync(vsync), .de(de), .frame_end(frame_end),
   .red(red), .green(green), .blue(blue)
);

// File: tb/tb_fb_scanout.sv
`timescale 1ns/1ps
module tb_fb_scanout;
   localparam int HA = 16, HF = 2, HS = 2, HB = 2;
   localparam int VA = 8,  VF = 1, VS = 1, VB = 1;
   localparam int HT = HA + HF + HS + HB;
   localparam int VT = VA + VF + VS + VB;
   localparam int FRAME = HT * VT;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] mode_w = '0, fb_w = '0, area_w = '0;
   logic [31:0] ram_addr, ram_rdata;
   logic        hsync, vsync, de, frame_end;
   logic [7:0]  red, green, blue;

   always #2 clk = ~clk;

   fb_scanout #(
      .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
      .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
      .ADDR_W(32), .SYNC_LOW(1'b0)
   ) dut (
      .clk(clk), .rst_n(rst_n), .mode_cfg(mode_w), .fb_cfg(fb_w), .area_cfg(area_w),
      .ram_addr(ram_addr), .ram_rdata(ram_rdata), .hsync(hsync), .vsync(vsync),
      .de(de), .frame_end(frame_end), .red(red), .green(green), .blue(blue)
   );

   logic [31:0] mem [0:4095];
   always @(posedge clk) ram_rdata <= mem[ram_addr[13:2]];

   int tests = 0, fails = 0;
   bit done = 0, lit_on = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] fbword(int ptr, int wid, int code);
      return (64'(code) << 15) | (64'(wid) << 9) | 64'(ptr);
   endfunction
   function automatic logic [63:0] areaword(int w1, int h1);
      return (64'(w1) << 32) | (64'(h1) << 44);
   endfunction
   function automatic int bytes_pp(logic [63:0] f);
      return (((f >> 15) & 31) == 2) ? 2 : 4;
   endfunction
   function automatic logic [31:0] model_addr(int x, int y, logic [63:0] f);
      int bpp = bytes_pp(f);
      int ptr = int'(f & 511);
      int wid = int'((f >> 9) & 63);
      return 32'(ptr * 8192 + y * wid * 64 * bpp + x * bpp);
   endfunction
   function automatic logic [7:0] grow(int c);
      return 8'((c << 3) | (c >> 2));
   endfunction

   // behavioural reference: position and the prediction for the pixel leaving it
   int mh = 0, mv = 0, ex = 0, ey = 0;
   bit e_de = 0, e_hs = 0, e_vs = 0, e_eof = 0;
   logic [23:0] e_rgb = '0;
   string e_req = "R7";

   always @(posedge clk) begin
      if (!rst_n) begin
         mh = 0; mv = 0;
         e_de = 0; e_hs = 0; e_vs = 0; e_eof = 0; e_rgb = '0; e_req = "R9";
      end else begin
         int code;
         bit vis;
         logic [31:0] a, w;
         code  = int'((fb_w >> 15) & 31);
         e_de  = (mh < HA) && (mv < VA);
         e_hs  = (mh >= HA + HF) && (mh < HA + HF + HS);
         e_vs  = (mv >= VA + VF) && (mv < VA + VF + VS);
         e_eof = (mh == HT - 1) && (mv == VT - 1);
         ex = mh; ey = mv;
         vis = e_de && mode_w[0] && (mh <= int'(area_w[43:32])) && (mv <= int'(area_w[54:44]));
         a = model_addr(mh, mv, fb_w);
         w = mem[a[13:2]];
         e_rgb = '0;
         e_req = "R7";
         if (vis && code == 0) begin
            e_rgb = {w[7:0], w[15:8], w[23:16]};
            e_req = "R5";
         end else if (vis && code == 2) begin
            int p;
            p = a[1] ? int'(w >> 16) : int'(w & 32'hFFFF);
            e_rgb = {grow(p & 31), grow((p >> 5) & 31), grow((p >> 10) & 31)};
            e_req = "R6";
         end else if (vis) begin
            e_req = "R8";
         end
         mh++;
         if (mh == HT) begin
            mh = 0;
            mv = (mv == VT - 1) ? 0 : mv + 1;
         end
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         if (!rst_n) begin // R9
            chk({hsync, vsync, de, frame_end, red, green, blue} == '0, "R9", "reset outputs",
                {hsync, vsync, de, frame_end, 4'd0, red, green, blue}, 32'd0);
            chk(ram_addr == 32'd0, "R9", "reset address", ram_addr, 32'd0);
         end else begin
            chk({hsync, vsync} == {e_hs, e_vs}, "R1", "sync", {30'd0, hsync, vsync}, {30'd0, e_hs, e_vs});
            chk(de == e_de, "R2", "de", {31'd0, de}, {31'd0, e_de});
            chk(frame_end == e_eof, "R3", "frame_end", {31'd0, frame_end}, {31'd0, e_eof});
            if (mh < HA && mv < VA)
               chk(ram_addr == model_addr(mh, mv, fb_w), "R4", "address", ram_addr, model_addr(mh, mv, fb_w));
            chk({red, green, blue} == e_rgb, e_req, "colour", {8'd0, red, green, blue}, {8'd0, e_rgb});
            if (lit_on && e_de && ex == 0 && ey == 0) // R6 literal expansion
               chk({red, green, blue} == 24'h84C642, "R6", "expand 10/18/08", {8'd0, red, green, blue}, 32'h0084C642);
         end
      end
   end

   task automatic frames(int n);
      repeat (n * FRAME) @(posedge clk);
      #1;
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = (i * 32'h9E37_79B1) ^ 32'h1234_5678;
      mem[0] = 32'h2310_2310;
      mem[1] = 32'h0000_8000;
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      frames(1);                                    // R9 zero configs, disabled
      fb_w = fbword(0, 1, 0); area_w = areaword(HA - 1, VA - 1);
      frames(1);                                    // R7 configured, disabled
      mode_w = 64'd1;
      frames(2);                                    // R5
      fb_w = fbword(0, 1, 2); lit_on = 1;
      frames(1);                                    // R6
      lit_on = 0;
      fb_w = fbword(1, 2, 2); area_w = areaword(5, 3);
      frames(1);                                    // R4 R6 R7 window
      fb_w = fbword(1, 3, 0); area_w = areaword(HA - 1, 4);
      frames(1);                                    // R4 R5
      fb_w = fbword(0, 1, 1);
      frames(1);                                    // R8
      fb_w = fbword(0, 1, 31);
      frames(1);                                    // R8
      fb_w = fbword(0, 1, 2); mode_w = 64'd0;
      frames(1);                                    // R7 disabled
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         tests++; fails++;
         $display("FAIL R3 watchdog actual=%0d expected=%0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule